// File: doc/BRIEF.md
# One-Time-Clear Byte Memory with Pin-Mode Decoder

This block is a synthesizable, cycle-based model of a byte-wide programmable memory. Each clock, it turns a small set of active-low control inputs and two high-voltage flags into one of seven operating modes. It then drives or releases its data output to match that mode. Software-visible registers are absent. The block is steered only by the levels on its pins, the same way a board-level memory part is steered from a host bus or from a programmer.

Cells start erased, with every bit at 1. A program cycle can only pull bits down to 0. The stored value becomes the old byte ANDed with the presented byte. Only the bulk erase input brings ones back, and it does so for the whole array in one clock. When the identification flag is raised in a read configuration, address bit 0 selects one of two fixed identifier bytes in place of array content.

The full part has a 14-bit address. The `AW` parameter defaults to 11 so that the elaborated array stays small; set `AW` = 14 for the full 16K x 8 organisation. All outputs are registered. A mode decoded from the pins at a rising edge takes effect on `dout` and `dout_en` right after that edge.

The decoder behaves as a seven-state machine. Its states are STANDBY, READ, OUT_OFF, SIG, PROG, VERIFY and INHIBIT. Every edge moves it to whichever state the present pins decode to, so the transition is named after its target. The transition into PROG from any other state is the only one that also commits a write.

Top module: `eprom_model`

## Requirements
- R1: While `rst_n` is low, `dout_en` and `dout` are 0 at once, without waiting for a clock. The first edge after release decodes normally. Array content is not changed by reset.
- R2: READ is `chip_en_n`=0, `out_en_n`=0, `prog_hv`=0 and `id_hv`=0. In READ, after the edge `dout_en` is 1 and `dout` holds the byte stored at `addr`.
- R3: OUT_OFF is `chip_en_n`=0, `out_en_n`=1 and `prog_hv`=0. In OUT_OFF, after the edge `dout_en` is 0 and `dout` is 8'h00.
- R4: STANDBY is `chip_en_n`=1 with `prog_hv`=0. In STANDBY, `dout_en` is 0 and `dout` is 8'h00 whatever the other pins are.
- R5: PROG is `prog_hv`=1, `chip_en_n`=0, `out_en_n`=1 and `prog_n`=0. Entering PROG replaces the byte at `addr` with (old AND `din`). The output stays released, and this holds at every address including the highest one.
- R6: One write happens per low period of `prog_n`. While PROG is held over several edges, later changes of `addr` or `din` store nothing.
- R7: VERIFY is `prog_hv`=1, `chip_en_n`=0, `out_en_n`=0 and `prog_n`=1. VERIFY drives the stored byte with `dout_en`=1.
- R8: With `prog_hv`=1, each of the following decodes INHIBIT, with no write and `dout_en`=0: `chip_en_n`=1; `prog_n`=1 together with `out_en_n`=1; or both `out_en_n` and `prog_n` low.
- R9: SIG is a READ configuration with `id_hv`=1. SIG drives 8'h97 when `addr[0]`=0 and 8'h83 when `addr[0]`=1, with `dout_en`=1.
- R10: `erase`=1 with `prog_hv`=0 sets every byte to 8'hFF at that edge, and `erase` is ignored while `prog_hv`=1. A READ in the same edge as an erase returns the pre-erase byte.
- R11: A bit programmed to 0 stays 0 under later program cycles with `din` bit = 1, until an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of mode and output registers |
| addr | input | AW | Byte address; bit 0 also selects the identifier byte |
| chip_en_n | input | 1 | Active-low chip select; high gives standby |
| out_en_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program strobe |
| prog_hv | input | 1 | Flag: programming voltage present |
| id_hv | input | 1 | Flag: high voltage on the identifier-select address pin |
| erase | input | 1 | Bulk erase request, sets every byte to all ones |
| din | input | DW | Byte presented for programming |
| dout | output | DW | Data driven when `dout_en` is 1, else zero |
| dout_en | output | 1 | Output driver enable; 0 stands for high impedance |

## Verification
A bulk erase and a READ can fall on the same edge, because erase does not depend on the decoded mode. The bench provokes this by holding a READ of a previously cleared byte while raising `erase` for one cycle. The value after that edge must still be the cleared byte, and the following READ must show 8'hFF. A program entry and a pending erase cannot share an edge, because one needs `prog_hv` high and the other needs it low. The bench shows this by raising `erase` under `prog_hv` and then reading back content that is unchanged.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    // Operating modes decoded from the control pins each cycle.
    typedef enum logic [2:0] {
        M_STANDBY = 3'd0,
        M_READ    = 3'd1,
        M_OUT_OFF = 3'd2,
        M_SIG     = 3'd3,
        M_PROG    = 3'd4,
        M_VERIFY  = 3'd5,
        M_INHIBIT = 3'd6
    } mode_e;

    // Modes in which the output driver is turned on.
    function automatic logic mode_drives(input mode_e m);
        return (m == M_READ) || (m == M_VERIFY) || (m == M_SIG);
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  chip_en_n,
    input  logic  out_en_n,
    input  logic  prog_n,
    input  logic  prog_hv,
    input  logic  id_hv,
    output mode_e mode_nx
);

    always_comb begin
        mode_nx = M_STANDBY;
        unique case ({prog_hv, chip_en_n})
            // Normal supply, selected: read family.
            2'b00: begin
                if (out_en_n)   mode_nx = M_OUT_OFF;
                else if (id_hv) mode_nx = M_SIG;
                else            mode_nx = M_READ;
            end
            // Normal supply, deselected: power-down.
            2'b01: mode_nx = M_STANDBY;
            // Programming supply, selected: strobe and enable decide.
            2'b10: begin
                unique case ({out_en_n, prog_n})
                    2'b10:   mode_nx = M_PROG;
                    2'b01:   mode_nx = M_VERIFY;
                    default: mode_nx = M_INHIBIT;
                endcase
            end
            // Programming supply, deselected: no write possible.
            2'b11: mode_nx = M_INHIBIT;
            default: mode_nx = M_STANDBY;
        endcase
    end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          erase_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    // Non-volatile content: deliberately not touched by reset.
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (erase_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            // Bits can only move from 1 to 0.
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
    import eprom_pkg::*;
#(
    parameter int          DW     = 8,
    parameter logic [DW-1:0] MFG_ID = 8'h97,
    parameter logic [DW-1:0] DEV_ID = 8'h83
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode_nx,
    input  logic [DW-1:0] cell_data,
    input  logic          id_sel,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    logic [DW-1:0] dout_d;

    always_comb begin
        dout_d = '0;
        unique case (mode_nx)
            M_READ, M_VERIFY: dout_d = cell_data;
            M_SIG:            dout_d = id_sel ? DEV_ID : MFG_ID;
            M_STANDBY, M_OUT_OFF, M_PROG, M_INHIBIT: dout_d = '0;
            default:          dout_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout    <= dout_d;
            dout_en <= mode_drives(mode_nx);
        end
    end

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int            AW     = 11,
    parameter int            DW     = 8,
    parameter logic [DW-1:0] MFG_ID = 8'h97,
    parameter logic [DW-1:0] DEV_ID = 8'h83
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          chip_en_n,
    input  logic          out_en_n,
    input  logic          prog_n,
    input  logic          prog_hv,
    input  logic          id_hv,
    input  logic          erase,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    mode_e         mode_nx;
    mode_e         mode_q;
    logic          wr_pulse;
    logic          erase_en;
    logic [DW-1:0] cell_data;

    eprom_mode_dec u_dec (
        .chip_en_n (chip_en_n),
        .out_en_n  (out_en_n),
        .prog_n    (prog_n),
        .prog_hv   (prog_hv),
        .id_hv     (id_hv),
        .mode_nx   (mode_nx)
    );

    // State register: last decoded mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_STANDBY;
        else        mode_q <= mode_nx;
    end

    // Entering PROG commits exactly one write per strobe low period.
    assign wr_pulse = rst_n && (mode_nx == M_PROG) && (mode_q != M_PROG);
    // Bulk erase only under normal supply.
    assign erase_en = rst_n && erase && !prog_hv;

    eprom_cell_array #(.AW(AW), .DW(DW)) u_cells (
        .clk      (clk),
        .wr_en    (wr_pulse),
        .wr_addr  (addr),
        .wr_data  (din),
        .erase_en (erase_en),
        .rd_addr  (addr),
        .rd_data  (cell_data)
    );

    eprom_out_stage #(.DW(DW), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_nx   (mode_nx),
        .cell_data (cell_data),
        .id_sel    (addr[0]),
        .dout      (dout),
        .dout_en   (dout_en)
    );

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int            DW     = 8,
    parameter logic [DW-1:0] MFG_ID = 8'h97,
    parameter logic [DW-1:0] DEV_ID = 8'h83
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chip_en_n,
    input logic          out_en_n,
    input logic          prog_n,
    input logic          prog_hv,
    input logic          id_hv,
    input logic          sel0,
    input logic [DW-1:0] dout,
    input logic          dout_en
);

    // R4
    standby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n && !prog_hv) |=> (!dout_en && dout == '0));

    // R3
    out_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && out_en_n && !prog_hv) |=> !dout_en);

    // R9
    ident_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && !out_en_n && !prog_hv && id_hv)
        |=> (dout_en && dout == ($past(sel0) ? DEV_ID : MFG_ID)));

    // R5
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hv && !chip_en_n && out_en_n && !prog_n) |=> !dout_en);

    // R7
    verify_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hv && !chip_en_n && !out_en_n && prog_n) |=> dout_en);

    // R8
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hv && chip_en_n) |=> !dout_en);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!dout_en && dout == '0));

endmodule

bind eprom_model eprom_model_chk #(.DW(DW), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_n (chip_en_n),
    .out_en_n  (out_en_n),
    .prog_n    (prog_n),
    .prog_hv   (prog_hv),
    .id_hv     (id_hv),
    .sel0      (addr[0]),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/tb_eprom_model.sv
module tb_eprom_model;

    localparam int AW = 11;
    localparam int DW = 8;

    typedef struct packed {
        logic          ce_n;
        logic          oe_n;
        logic          pr_n;
        logic          hv;
        logic          idv;
        logic          ers;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          x_en;
        logic [DW-1:0] x_do;
        logic [3:0]    req;
    } vec_t;

    function automatic vec_t mk(input logic ce_n, oe_n, pr_n, hv, idv, ers,
                                input int a, input logic [7:0] d,
                                input logic x_en, input logic [7:0] x_do,
                                input int req);
        vec_t v;
        v.ce_n = ce_n; v.oe_n = oe_n; v.pr_n = pr_n; v.hv = hv; v.idv = idv;
        v.ers = ers; v.a = AW'(a); v.d = d; v.x_en = x_en; v.x_do = x_do;
        v.req = 4'(req);
        return v;
    endfunction

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        mk(1,1,1,0,0,1, 0, 8'h00, 0, 8'h00, 10), // R10 erase in standby
        mk(0,0,1,0,0,0, 5, 8'h00, 1, 8'hFF,  2), // R2 read erased byte
        mk(0,1,0,1,0,0, 5, 8'hA5, 0, 8'h00,  5), // R5 program
        mk(0,1,1,1,0,0, 5, 8'hA5, 0, 8'h00,  8), // R8 inhibit, strobe high
        mk(0,0,1,1,0,0, 5, 8'h00, 1, 8'hA5,  7), // R7 verify
        mk(0,1,0,1,0,0, 5, 8'h5A, 0, 8'h00, 11), // R11 program over A5
        mk(0,0,1,1,0,0, 5, 8'h00, 1, 8'h00, 11), // R11 AND result
        mk(0,1,0,1,0,0, 7, 8'h0F, 0, 8'h00,  5), // R5 program addr 7
        mk(0,1,0,1,0,0, 9, 8'h00, 0, 8'h00,  6), // R6 strobe held, addr moves
        mk(1,1,0,1,0,0, 9, 8'h00, 0, 8'h00,  8), // R8 inhibit, chip deselected
        mk(0,0,1,0,0,0, 9, 8'h00, 1, 8'hFF,  6), // R6 addr 9 untouched
        mk(0,0,1,0,0,0, 7, 8'h00, 1, 8'h0F,  5), // R5 addr 7 stored
        mk(0,1,1,0,0,0, 7, 8'h00, 0, 8'h00,  3), // R3 output disable
        mk(0,0,1,0,1,0, 0, 8'h00, 1, 8'h97,  9), // R9 maker byte
        mk(0,0,1,0,1,0, 1, 8'h00, 1, 8'h83,  9), // R9 type byte
        mk(1,0,0,0,1,0, 7, 8'h00, 0, 8'h00,  4), // R4 standby
        mk(1,1,1,1,0,1, 7, 8'h00, 0, 8'h00, 10), // R10 erase under hv
        mk(0,0,1,0,0,0, 7, 8'h00, 1, 8'h0F, 10), // R10 erase ignored
        mk(0,0,1,0,0,1, 5, 8'h00, 1, 8'h00, 10), // R10 read + erase same edge
        mk(0,0,1,0,0,0, 5, 8'h00, 1, 8'hFF, 10), // R10 erased
        mk(0,0,1,0,0,0, 7, 8'h00, 1, 8'hFF, 10), // R10 erased
        mk(0,0,0,1,0,0, 7, 8'h00, 0, 8'h00,  8), // R8 both low
        mk(0,0,1,0,0,0, 7, 8'h00, 1, 8'hFF,  8)  // R8 no write
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          chip_en_n, out_en_n, prog_n, prog_hv, id_hv, erase;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    eprom_model #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en_n(chip_en_n),
        .out_en_n(out_en_n), .prog_n(prog_n), .prog_hv(prog_hv),
        .id_hv(id_hv), .erase(erase), .din(din), .dout(dout),
        .dout_en(dout_en)
    );

    task automatic check(input int req, input logic x_en, input logic [7:0] x_do);
        n_run++;
        if (dout_en !== x_en || dout !== x_do) begin
            n_fail++;
            $display("FAIL R%0d: actual en=%0b dout=%h expected en=%0b dout=%h",
                     req, dout_en, dout, x_en, x_do);
        end
    endtask

    task automatic drive(input vec_t v);
        chip_en_n = v.ce_n; out_en_n = v.oe_n; prog_n = v.pr_n;
        prog_hv = v.hv; id_hv = v.idv; erase = v.ers; addr = v.a; din = v.d;
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        check(int'(v.req), v.x_en, v.x_do);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(mk(0,0,1,0,0,0, 3, 8'h00, 0, 8'h00, 1)); // read pins during reset
        repeat (3) @(negedge clk);
        check(1, 1'b0, 8'h00); // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
        end

        // R5 highest address, R2 address 0 unaffected
        step(mk(0,1,0,1,0,0, (1<<AW)-1, 8'h3C, 0, 8'h00, 5));
        step(mk(0,0,1,1,0,0, (1<<AW)-1, 8'h00, 1, 8'h3C, 5));
        step(mk(0,0,1,0,0,0, 0, 8'h00, 1, 8'hFF, 2));

        // R1 asynchronous reset during a read; content kept
        step(mk(0,0,1,0,0,0, (1<<AW)-1, 8'h00, 1, 8'h3C, 2));
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b1, 8'h3C); // R1 first edge after release decodes read

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule